// File: doc/BRIEF.md
# Microsequencer Next-Address Unit

This block selects the control-store address of the next microinstruction in a microcoded controller for a 16-bit load/store processor. It takes the sequencing fields of the microinstruction now executing (a 6-bit jump target, a 2-bit condition selector and a decode flag), the upper bits of the instruction register, the memory ready signal and a held branch-enable bit. From these it forms a 6-bit address. With the decode flag set, the address is the 4-bit opcode with two zeros above it, which dispatches 16 ways. Otherwise it is the jump target, with the one selected condition ORed into one fixed low bit.

The block also holds the branch-enable flag. When a load strobe is asserted, this flag captures whether any condition-code flag picked out by the instruction's three test bits is set. Two small multiplexers produce the destination and first-source register numbers for the register file. The address path is purely combinational, so a control-store read can follow it in the same cycle. The only state is the branch-enable flag.

Top module: `useq_sequencer`

## Requirements
- R1: When `seq_decode` is 1, `next_addr` equals two zero bits followed by IR[15:12] (`ir_upper[9:6]`). The jump field, condition code and all condition inputs have no effect.
- R2: When `seq_decode` is 0 and `seq_cond` is 2'b00 (unconditional), `next_addr` equals `seq_jump` exactly.
- R3: When `seq_decode` is 0 and `seq_cond` is 2'b01 (memory wait), bit 1 of `next_addr` is `seq_jump[1]` OR `mem_ready`. Every other bit equals `seq_jump`.
- R4: When `seq_decode` is 0 and `seq_cond` is 2'b10 (branch), bit 2 of `next_addr` is `seq_jump[2]` OR the held branch-enable flag. Every other bit equals `seq_jump`.
- R5: When `seq_decode` is 0 and `seq_cond` is 2'b11 (addressing mode), bit 0 of `next_addr` is `seq_jump[0]` OR IR[11] (`ir_upper[5]`). Every other bit equals `seq_jump`.
- R6: On a clock edge with `ld_ben` high, `ben` takes (IR[11]&`flag_n`) | (IR[10]&`flag_z`) | (IR[9]&`flag_p`). IR[11:9] is `ir_upper[5:3]`.
- R7: On a clock edge with `ld_ben` low, `ben` keeps its value whatever the flags and IR bits are.
- R8: A clock edge with `rst_n` low clears `ben` to 0.
- R9: `dst_reg` is IR[11:9] when `dr_sel` is 0 and 3'b111 when `dr_sel` is 1.
- R10: `src1_reg` is IR[11:9] when `sr1_sel` is 0 and IR[8:6] (`ir_upper[2:0]`) when `sr1_sel` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| seq_jump | input | 6 | Jump target field of the current microinstruction |
| seq_cond | input | 2 | Condition selector: 00 always, 01 memory wait, 10 branch, 11 addressing mode |
| seq_decode | input | 1 | Opcode dispatch flag |
| ir_upper | input | 10 | Instruction register bits 15 down to 6 |
| mem_ready | input | 1 | Memory access completed |
| flag_n | input | 1 | Negative condition-code flag |
| flag_z | input | 1 | Zero condition-code flag |
| flag_p | input | 1 | Positive condition-code flag |
| ld_ben | input | 1 | Load strobe for the branch-enable flag |
| dr_sel | input | 1 | Destination select: 0 IR[11:9], 1 register 7 |
| sr1_sel | input | 1 | First-source select: 0 IR[11:9], 1 IR[8:6] |
| next_addr | output | 6 | Address of the next microinstruction |
| ben | output | 1 | Held branch-enable flag |
| dst_reg | output | 3 | Destination register number |
| src1_reg | output | 3 | First-source register number |

## Verification
The bench uses jump targets whose condition bit is already 1. A design that replaced that bit instead of ORing into it would clear it when the condition is low. It also drives live condition inputs under unselected codes and under decode, where a design that ORed every condition into the address would show stray bits. Branch enable is loaded from each of the three test-bit/flag pairs and then held with the strobe low while the flags change. A flag that followed its inputs freely, or that sampled the wrong pair, would show in the branch address. A reset in the middle of the run confirms that the flag clears.

// File: rtl/useq_pkg.sv
// Shared widths and condition codes for the microsequencer.
// Assumes a 16-bit instruction word whose top four bits are the opcode.
package useq_pkg;
    localparam int ADDR_W = 6;
    localparam int OPC_W  = 4;
    localparam int REG_W  = 3;

    typedef enum logic [1:0] {
        COND_ALWAYS = 2'b00,
        COND_MEMRDY = 2'b01,
        COND_BRANCH = 2'b10,
        COND_MODE   = 2'b11
    } cond_e;
endpackage

// File: rtl/useq_ben_reg.sv
// Branch-enable flag: captures whether any condition-code flag picked out by
// the instruction's three test bits is set, on a load strobe.
// Assumes test bits ordered {n, z, p} from high to low.
module useq_ben_reg (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       load,
    input  logic [2:0] test_bits,
    input  logic       flag_n,
    input  logic       flag_z,
    input  logic       flag_p,
    output logic       ben
);
    logic hit;

    // Combine the test bits with the matching flags.
    always_comb hit = |(test_bits & {flag_n, flag_z, flag_p});

    // Hold the flag; reload only on the strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ben <= 1'b0;
        else if (load)
            ben <= hit;
    end

    // R6: a strobe captures the evaluated test
    a_r6_ben_load: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> ben == $past((test_bits[2] & flag_n) | (test_bits[1] & flag_z) | (test_bits[0] & flag_p)));
    // R7: without a strobe the flag holds
    a_r7_ben_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(ben));
    // R8: reset clears the flag
    a_r8_ben_reset: assert property (@(posedge clk)
        !rst_n |=> !ben);
endmodule

// File: rtl/useq_reg_select.sv
// Register-number multiplexers for destination and first source.
// Assumes the link register is the all-ones register number.
module useq_reg_select #(
    parameter int REG_W = 3
) (
    input  logic [REG_W-1:0] field_hi,
    input  logic [REG_W-1:0] field_lo,
    input  logic             dr_sel,
    input  logic             sr1_sel,
    output logic [REG_W-1:0] dst_reg,
    output logic [REG_W-1:0] src1_reg
);
    localparam logic [REG_W-1:0] LINK_REG = '1;

    // Destination: instruction field or the link register.
    always_comb dst_reg = dr_sel ? LINK_REG : field_hi;

    // First source: upper or lower instruction field.
    always_comb src1_reg = sr1_sel ? field_lo : field_hi;
endmodule

// File: rtl/useq_next_addr.sv
// Combinational next-address former: opcode dispatch, or the jump field with
// the one selected condition ORed into its fixed bit.
// Assumes the condition bit positions lie inside the address width.
module useq_next_addr
    import useq_pkg::*;
#(
    parameter int ADDR_W     = 6,
    parameter int OPC_W      = 4,
    parameter int MODE_BIT   = 0,
    parameter int READY_BIT  = 1,
    parameter int BRANCH_BIT = 2
) (
    input  logic [ADDR_W-1:0] jump,
    input  logic [1:0]        cond,
    input  logic              decode,
    input  logic [OPC_W-1:0]  opcode,
    input  logic              mode,
    input  logic              ready,
    input  logic              branch,
    output logic [ADDR_W-1:0] next_addr
);
    localparam int PAD_W = ADDR_W - OPC_W;

    logic [ADDR_W-1:0] inject;
    logic [ADDR_W-1:0] dispatch;

    // Place the selected condition into its bit; others stay zero.
    always_comb begin
        inject = '0;
        case (cond_e'(cond))
            COND_MEMRDY: inject[READY_BIT]  = ready;
            COND_BRANCH: inject[BRANCH_BIT] = branch;
            COND_MODE:   inject[MODE_BIT]   = mode;
            default:     inject = '0;
        endcase
    end

    // Zero-extend the opcode when the address is wider than it.
    generate
        if (PAD_W > 0) begin : g_pad
            always_comb dispatch = {{PAD_W{1'b0}}, opcode};
        end else begin : g_nopad
            always_comb dispatch = opcode[ADDR_W-1:0];
        end
    endgenerate

    // Choose dispatch or conditioned jump.
    always_comb next_addr = decode ? dispatch : (jump | inject);
endmodule

// File: rtl/useq_sequencer.sv
// Microsequencer top: next microinstruction address, branch-enable flag and
// register-number selection. Assumes ir_upper carries IR[15:6].
module useq_sequencer
    import useq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] seq_jump,
    input  logic [1:0]        seq_cond,
    input  logic              seq_decode,
    input  logic [9:0]        ir_upper,
    input  logic              mem_ready,
    input  logic              flag_n,
    input  logic              flag_z,
    input  logic              flag_p,
    input  logic              ld_ben,
    input  logic              dr_sel,
    input  logic              sr1_sel,
    output logic [ADDR_W-1:0] next_addr,
    output logic              ben,
    output logic [REG_W-1:0]  dst_reg,
    output logic [REG_W-1:0]  src1_reg
);
    localparam int MODE_BIT   = 0;
    localparam int READY_BIT  = 1;
    localparam int BRANCH_BIT = 2;
    localparam int OPC_LSB    = 10 - OPC_W;
    localparam int HI_LSB     = OPC_LSB - REG_W;
    localparam logic [ADDR_W-1:0] M_MODE   = ADDR_W'(1) << MODE_BIT;
    localparam logic [ADDR_W-1:0] M_READY  = ADDR_W'(1) << READY_BIT;
    localparam logic [ADDR_W-1:0] M_BRANCH = ADDR_W'(1) << BRANCH_BIT;

    logic [OPC_W-1:0] opcode;
    logic [REG_W-1:0] field_hi;
    logic [REG_W-1:0] field_lo;

    // Split the instruction bits into named fields.
    always_comb begin
        opcode   = ir_upper[9:OPC_LSB];
        field_hi = ir_upper[OPC_LSB-1:HI_LSB];
        field_lo = ir_upper[HI_LSB-1:0];
    end

    useq_ben_reg u_ben (
        .clk(clk), .rst_n(rst_n), .load(ld_ben), .test_bits(field_hi),
        .flag_n(flag_n), .flag_z(flag_z), .flag_p(flag_p), .ben(ben)
    );

    useq_next_addr #(
        .ADDR_W(ADDR_W), .OPC_W(OPC_W), .MODE_BIT(MODE_BIT),
        .READY_BIT(READY_BIT), .BRANCH_BIT(BRANCH_BIT)
    ) u_next (
        .jump(seq_jump), .cond(seq_cond), .decode(seq_decode), .opcode(opcode),
        .mode(field_hi[REG_W-1]), .ready(mem_ready), .branch(ben),
        .next_addr(next_addr)
    );

    useq_reg_select #(.REG_W(REG_W)) u_regs (
        .field_hi(field_hi), .field_lo(field_lo), .dr_sel(dr_sel),
        .sr1_sel(sr1_sel), .dst_reg(dst_reg), .src1_reg(src1_reg)
    );

    // R1: decode dispatches on the opcode only
    a_r1_dispatch: assert property (@(posedge clk) disable iff (!rst_n)
        seq_decode |-> next_addr == {{(ADDR_W-OPC_W){1'b0}}, ir_upper[9:6]});
    // R2: unconditional passes the jump field through
    a_r2_plain_jump: assert property (@(posedge clk) disable iff (!rst_n)
        (!seq_decode && seq_cond == 2'b00) |-> next_addr == seq_jump);
    // R3: memory wait touches only the ready bit
    a_r3_ready_bit: assert property (@(posedge clk) disable iff (!rst_n)
        (!seq_decode && seq_cond == 2'b01) |->
        ((next_addr & ~M_READY) == (seq_jump & ~M_READY)) && (next_addr[READY_BIT] == (seq_jump[READY_BIT] | mem_ready)));
    // R4: branch touches only the branch bit
    a_r4_branch_bit: assert property (@(posedge clk) disable iff (!rst_n)
        (!seq_decode && seq_cond == 2'b10) |->
        ((next_addr & ~M_BRANCH) == (seq_jump & ~M_BRANCH)) && (next_addr[BRANCH_BIT] == (seq_jump[BRANCH_BIT] | ben)));
    // R5: addressing mode touches only the mode bit
    a_r5_mode_bit: assert property (@(posedge clk) disable iff (!rst_n)
        (!seq_decode && seq_cond == 2'b11) |->
        ((next_addr & ~M_MODE) == (seq_jump & ~M_MODE)) && (next_addr[MODE_BIT] == (seq_jump[MODE_BIT] | ir_upper[5])));
    // R9: link select yields register 7
    a_r9_link_dst: assert property (@(posedge clk) disable iff (!rst_n)
        dr_sel |-> dst_reg == 3'b111);
    // R10: source select picks IR[8:6]
    a_r10_src_low: assert property (@(posedge clk) disable iff (!rst_n)
        sr1_sel |-> src1_reg == ir_upper[2:0]);
endmodule

// File: tb/useq_sequencer_bench.sv
module useq_sequencer_bench;
    logic       clk = 0;
    logic       rst_n = 0;
    logic [5:0] seq_jump = 0;
    logic [1:0] seq_cond = 0;
    logic       seq_decode = 0;
    logic [9:0] ir_upper = 0;
    logic       mem_ready = 0, flag_n = 0, flag_z = 0, flag_p = 0;
    logic       ld_ben = 0, dr_sel = 0, sr1_sel = 0;
    logic [5:0] next_addr;
    logic       ben;
    logic [2:0] dst_reg, src1_reg;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    useq_sequencer u_useq_sequencer (
        .clk(clk), .rst_n(rst_n), .seq_jump(seq_jump), .seq_cond(seq_cond),
        .seq_decode(seq_decode), .ir_upper(ir_upper), .mem_ready(mem_ready),
        .flag_n(flag_n), .flag_z(flag_z), .flag_p(flag_p), .ld_ben(ld_ben),
        .dr_sel(dr_sel), .sr1_sel(sr1_sel), .next_addr(next_addr), .ben(ben),
        .dst_reg(dst_reg), .src1_reg(src1_reg)
    );

    // {decode, cond[1:0], jump[5:0], IR[15:11], ready, expected[5:0]}
    localparam int NV = 10;
    localparam logic [20:0] VEC [NV] = '{
        {1'b1, 2'b00, 6'h3F, 5'b10101, 1'b1, 6'h0A},  // R1
        {1'b1, 2'b11, 6'h00, 5'b01100, 1'b0, 6'h06},  // R1
        {1'b0, 2'b00, 6'h25, 5'b11111, 1'b1, 6'h25},  // R2
        {1'b0, 2'b01, 6'h20, 5'b00000, 1'b1, 6'h22},  // R3
        {1'b0, 2'b01, 6'h20, 5'b00000, 1'b0, 6'h20},  // R3
        {1'b0, 2'b01, 6'h1D, 5'b00001, 1'b0, 6'h1D},  // R3
        {1'b0, 2'b11, 6'h14, 5'b00001, 1'b0, 6'h15},  // R5
        {1'b0, 2'b11, 6'h14, 5'b00000, 1'b1, 6'h14},  // R5
        {1'b0, 2'b11, 6'h21, 5'b00000, 1'b0, 6'h21},  // R5
        {1'b0, 2'b00, 6'h12, 5'b00001, 1'b1, 6'h12}   // R2
    };

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Load branch enable from IR[11:9] and flags, then drop the strobe.
    task automatic load_ben(input logic [2:0] tb, input logic n, input logic z, input logic p);
        @(negedge clk);
        ir_upper[5:3] = tb; flag_n = n; flag_z = z; flag_p = p; ld_ben = 1;
        @(negedge clk);
        ld_ben = 0;
    endtask

    initial begin
        repeat (10000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R8 reset ben", ben, 0);
        rst_n = 1;
        // R8 ben is 0: branch-coded vectors are not in the table
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            {seq_decode, seq_cond, seq_jump} = VEC[i][20:12];
            ir_upper = {VEC[i][11:7], 5'b0};
            mem_ready = VEC[i][6];
            flag_n = 1; flag_z = 1; flag_p = 1;
            #1;
            check($sformatf("R1/R2/R3/R5 vec %0d", i), next_addr, VEC[i][5:0]);
        end
        // R1: dispatch ignores a set branch flag
        load_ben(3'b100, 1, 0, 0);
        check("R6 n test", ben, 1);
        seq_decode = 1; seq_cond = 2'b10; seq_jump = 6'h3F; ir_upper[9:6] = 4'h3; #1;
        check("R1 dispatch with ben", next_addr, 6'h03);
        seq_decode = 0; seq_jump = 6'h00; #1;
        check("R4 branch taken", next_addr, 6'h04);
        seq_jump = 6'h2B; #1;
        check("R4 other bits kept", next_addr, 6'h2F);
        seq_cond = 2'b00; seq_jump = 6'h08; #1;
        check("R2 ben ignored", next_addr, 6'h08);
        // R7: strobe low, flags changed, flag holds
        @(negedge clk);
        ir_upper[5:3] = 3'b000; flag_n = 0;
        @(negedge clk);
        check("R7 hold", ben, 1);
        load_ben(3'b010, 1, 0, 1);
        check("R6 z miss", ben, 0);
        seq_cond = 2'b10; seq_jump = 6'h18; #1;
        check("R4 not taken", next_addr, 6'h18);
        seq_jump = 6'h1C; #1;
        check("R4 jump bit kept", next_addr, 6'h1C);
        load_ben(3'b010, 0, 1, 0);
        check("R6 z hit", ben, 1);
        load_ben(3'b001, 0, 0, 1);
        check("R6 p hit", ben, 1);
        load_ben(3'b110, 0, 0, 1);
        check("R6 p unselected", ben, 0);
        load_ben(3'b001, 0, 0, 1);
        @(negedge clk); rst_n = 0;
        @(negedge clk);
        check("R8 mid reset", ben, 0);
        rst_n = 1;
        // R9 / R10 register selection, IR[11:9]=101, IR[8:6]=011
        @(negedge clk);
        ir_upper[5:0] = 6'b101011; dr_sel = 0; sr1_sel = 0; #1;
        check("R9 dst field", dst_reg, 5);
        check("R10 src hi", src1_reg, 5);
        dr_sel = 1; sr1_sel = 1; #1;
        check("R9 dst link", dst_reg, 7);
        check("R10 src lo", src1_reg, 3);
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule